// File: doc/BRIEF.md
# Supervisor-Call Interruption PSW Swapper

This block performs the storage half of a supervisor-call interruption. It accepts a start pulse together with the current 64-bit program status word, the operand byte of the supervisor-call instruction, and a flag that says whether the call was reached through an execute-type instruction. From these it forms a 16-bit interruption code and a 2-bit instruction-length code. It writes them to storage in the layout that the mode of the old PSW selects. It then stores the old PSW, reads the new PSW, loads it onto its output, and pulses done.

The PSW carries one of two formats. Bit 12 selects the format, with bits numbered from 0 at the most significant end. When bit 12 is 1 (extended format), the codes go into a separate low-storage doubleword. When bit 12 is 0 (basic format), the codes are merged into the old PSW before it is stored. All storage traffic uses one doubleword port with byte enables and a request/ready handshake. A request stays asserted, unchanged, until ready is returned.

Top module: `svc_psw_swap`

## Requirements
- R1: After reset, mem_req_o, done_o and busy_o are 0, and new_psw_o is all zeros.
- R2: In extended format, the first access is a write to address 136 with byte enables 8'hF0. The byte enable bit 7 and the data bits 63:56 belong to the lowest byte address. The write data is {8'h00, {5'b0, ilc, 1'b0}, 8'h00, svc_byte, 32'h0}: the length code sits in bits 5-6 of byte 137, and bytes 136 and 138 are zero.
- R3: The length code (ilc) is 2'd2 when via_exec_i was 1 at start, and 2'd1 otherwise. The interruption code is {8'h00, svc_byte}.
- R4: In extended format, the old PSW is written to address 32 with byte enables 8'hFF, unchanged from the PSW that was captured at start.
- R5: In basic format, no code write is made. The PSW written to address 32 has PSW bits 16-31 (data bits 47:32) replaced by the interruption code and PSW bits 32-33 (data bits 31:30) replaced by ilc. All other bits are unchanged.
- R6: The access order is fixed: code write (extended format only), then old-PSW write, then a read of address 96 with byte enables 8'hFF. Each operation makes no other access.
- R7: While mem_req_o is 1 and mem_ready_i is 0, the request's address, write enable, byte enables and write data hold stable.
- R8: new_psw_o takes the read data of the address-96 access. done_o pulses for exactly one cycle, in the cycle after the read handshake.
- R9: The inputs are captured in the start cycle. Changes to start_i, psw_i, svc_byte_i and via_exec_i while busy_o is 1 (including the done cycle) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an interruption swap (taken when idle) |
| psw_i | input | 64 | Current PSW |
| svc_byte_i | input | 8 | Operand byte of the supervisor-call instruction |
| via_exec_i | input | 1 | Call was reached through an execute-type instruction |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the new PSW is loaded |
| new_psw_o | output | 64 | Loaded new PSW |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 24 | Byte address of the doubleword |
| mem_be_o | output | 8 | Byte enables, bit 7 = lowest address |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle; read data is valid with it |
| mem_rdata_i | input | 64 | Read data |

## Verification
Two things can happen in the same cycle: a fresh start request and the tail of the running swap. This covers a request that arrives during the done pulse or during a stalled memory handshake. To provoke it, the bench holds start_i high through every swap, including its done cycle. It also scrambles psw_i, svc_byte_i and via_exec_i right after capture. It then judges the result by checking that each swap produced exactly the expected access list and a single done pulse, with data built from the captured inputs only. The sweep covers every operand byte in both formats and both length codes, with a rotating number of memory stall cycles.

// File: rtl/svc_swap_pkg.sv
package svc_swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CODE,
    ST_OLD,
    ST_NEW,
    ST_DONE
  } swap_state_e;

  function automatic logic [1:0] ilc_of(input logic via_exec);
    return via_exec ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/svc_code_gen.sv
module svc_code_gen #(
  parameter int DW     = 64,
  parameter int EC_BIT = 12
) (
  input  logic [DW-1:0] psw_i,
  input  logic [7:0]    svc_byte_i,
  input  logic          via_exec_i,
  output logic          ec_mode_o,
  output logic [1:0]    ilc_o,
  output logic [DW-1:0] code_word_o,
  output logic [DW-1:0] old_word_o
);
  import svc_swap_pkg::*;

  localparam int EC_POS   = DW - 1 - EC_BIT;
  localparam int CODE_TOP = DW - 1 - 16;
  localparam int ILC_TOP  = DW - 1 - 32;

  logic [15:0] int_code;

  assign ec_mode_o = psw_i[EC_POS];
  assign ilc_o     = ilc_of(via_exec_i);
  assign int_code  = {8'h00, svc_byte_i};

  always_comb begin
    code_word_o = '0;
    code_word_o[DW-1 -: 32] = {8'h00, 5'b0, ilc_o, 1'b0, int_code};
  end

  always_comb begin
    old_word_o = psw_i;
    if (!ec_mode_o) begin
      old_word_o[CODE_TOP -: 16] = int_code;
      old_word_o[ILC_TOP -: 2]   = ilc_o;
    end
  end
endmodule

// File: rtl/svc_seq.sv
module svc_seq (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       ec_mode_i,
  input  logic                       mem_ready_i,
  output svc_swap_pkg::swap_state_e  state_o,
  output logic                       capture_o,
  output logic                       load_o,
  output logic                       busy_o,
  output logic                       done_o
);
  import svc_swap_pkg::*;

  swap_state_e state_q, state_d;

  assign capture_o = (state_q == ST_IDLE) && start_i;
  assign load_o    = (state_q == ST_NEW) && mem_ready_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CODE;
      ST_CODE: if (!ec_mode_i) state_d = ST_OLD;
               else if (mem_ready_i) state_d = ST_OLD;
      ST_OLD:  if (mem_ready_i) state_d = ST_NEW;
      ST_NEW:  if (mem_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R8: done follows the read handshake and lasts one cycle
  assert_done_after_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> done_o);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9: a start while busy does not restart the sequence
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_DONE) |=> busy_o);
endmodule

// File: rtl/svc_psw_swap.sv
module svc_psw_swap #(
  parameter int ADDR_W        = 24,
  parameter int DW            = 64,
  parameter int EC_BIT        = 12,
  parameter int OLD_PSW_ADDR  = 32,
  parameter int NEW_PSW_ADDR  = 96,
  parameter int CODE_DW_ADDR  = 136
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     psw_i,
  input  logic [7:0]        svc_byte_i,
  input  logic              via_exec_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     new_psw_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW/8-1:0]   mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  import svc_swap_pkg::*;

  localparam int BE_W = DW / 8;
  localparam logic [BE_W-1:0] BE_ALL  = '1;
  localparam logic [BE_W-1:0] BE_CODE = BE_ALL << (BE_W - 4);

  swap_state_e       state;
  logic              capture, load;
  logic [DW-1:0]     psw_q, new_psw_q;
  logic [7:0]        svc_q;
  logic              exec_q;
  logic              ec_mode;
  logic [1:0]        ilc;
  logic [DW-1:0]     code_word, old_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q  <= '0;
      svc_q  <= '0;
      exec_q <= 1'b0;
    end else if (capture) begin
      psw_q  <= psw_i;
      svc_q  <= svc_byte_i;
      exec_q <= via_exec_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   new_psw_q <= '0;
    else if (load) new_psw_q <= mem_rdata_i;
  end
  assign new_psw_o = new_psw_q;

  svc_code_gen #(.DW(DW), .EC_BIT(EC_BIT)) u_code_gen (
    .psw_i       (psw_q),
    .svc_byte_i  (svc_q),
    .via_exec_i  (exec_q),
    .ec_mode_o   (ec_mode),
    .ilc_o       (ilc),
    .code_word_o (code_word),
    .old_word_o  (old_word)
  );

  svc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ec_mode_i   (ec_mode),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .capture_o   (capture),
    .load_o      (load),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    unique case (state)
      ST_CODE: if (ec_mode) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ADDR_W'(CODE_DW_ADDR);
        mem_be_o    = BE_CODE;
        mem_wdata_o = code_word;
      end
      ST_OLD: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ADDR_W'(OLD_PSW_ADDR);
        mem_be_o    = BE_ALL;
        mem_wdata_o = old_word;
      end
      ST_NEW: begin
        mem_req_o   = 1'b1;
        mem_addr_o  = ADDR_W'(NEW_PSW_ADDR);
        mem_be_o    = BE_ALL;
      end
      default: ;
    endcase
  end

  // R7: a stalled request holds its contents
  assert_stall_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_be_o) && $stable(mem_wdata_o)));
  // R6: reads only target the new-PSW slot
  assert_read_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o == ADDR_W'(NEW_PSW_ADDR)));
  // R5: no code-byte write in basic format
  assert_bc_no_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_addr_o == ADDR_W'(CODE_DW_ADDR)) |-> psw_q[DW-1-EC_BIT]);
  // R6: old-PSW write is followed by the new-PSW read
  assert_old_then_new_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && mem_we_o && mem_addr_o == ADDR_W'(OLD_PSW_ADDR))
      |=> (mem_req_o && !mem_we_o));
  // R1: idle means no traffic
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R3: length code is one of the two legal values
  assert_ilc_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $countones(ilc) == 1);
endmodule

// File: tb/svc_psw_swap_bench.sv
module svc_psw_swap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] psw = '0;
  logic [7:0]  svc = '0;
  logic        vexec = 1'b0;
  logic        busy, done;
  logic [63:0] new_psw;
  logic        req, we;
  logic [23:0] addr;
  logic [7:0]  be;
  logic [63:0] wdata;
  logic        ready = 1'b0;
  logic [63:0] rdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  svc_psw_swap u_svc_psw_swap (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .psw_i(psw),
    .svc_byte_i(svc), .via_exec_i(vexec), .busy_o(busy), .done_o(done),
    .new_psw_o(new_psw), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_be_o(be), .mem_wdata_o(wdata), .mem_ready_i(ready), .mem_rdata_i(rdata)
  );

  // memory model: logs accepted requests, stalls by stall_len cycles
  int          stall_len = 0;
  int          wcnt = 0;
  logic        hs = 1'b0;
  logic        prev_stall = 1'b0;
  logic [23:0] p_addr;
  logic        p_we;
  logic [7:0]  p_be;
  logic [63:0] p_wdata;
  int          n_log = 0;
  logic [23:0] l_addr [8];
  logic        l_we   [8];
  logic [7:0]  l_be   [8];
  logic [63:0] l_data [8];
  int          l_cyc  [8];
  int          n_done = 0;
  int          done_cyc = 0;

  task automatic check(input bit ok, input string req_tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (hs) begin wcnt = 0; hs = 1'b0; end
    if (prev_stall && req)
      check(addr == p_addr && we == p_we && be == p_be && wdata == p_wdata,
            "R7 stall hold", {40'h0, addr}, {40'h0, p_addr});
    if (done) begin n_done++; done_cyc = cyc; end
    if (req) begin
      if (wcnt >= stall_len) begin
        ready = 1'b1;
        hs = 1'b1;
        if (n_log < 8) begin
          l_addr[n_log] = addr; l_we[n_log] = we; l_be[n_log] = be;
          l_data[n_log] = wdata; l_cyc[n_log] = cyc;
        end
        n_log++;
        prev_stall = 1'b0;
      end else begin
        ready = 1'b0;
        wcnt++;
        prev_stall = 1'b1;
        p_addr = addr; p_we = we; p_be = be; p_wdata = wdata;
      end
    end else begin
      ready = 1'b0;
      wcnt = 0;
      prev_stall = 1'b0;
    end
  end

  task automatic run_trial(input logic [7:0] s, input bit ex, input bit ec, input int st);
    logic [63:0] p, exp_old, exp_code, rd;
    logic [1:0]  ilc;
    int          k, guard;
    ilc = ex ? 2'd2 : 2'd1;                                        // R3
    p = {s, ~s, 8'h5A ^ s, s, 24'hC3A5F0 ^ {3{s}}, 8'h99};
    p[63-12] = ec;
    rd = {s ^ 8'h3C, 56'h0123_4567_89AB_CD} ^ {8{s}};
    exp_code = ({48'h0, 8'h00, s} << 32) | (64'(ilc) << 49);       // R2
    exp_old = p;
    if (!ec) exp_old = (p & ~(64'hFFFF << 32) & ~(64'h3 << 30))
                       | (64'(s) << 32) | (64'(ilc) << 30);        // R5
    @(negedge clk);
    n_log = 0; n_done = 0; stall_len = st; rdata = rd;
    psw = p; svc = s; vexec = ex; start = 1'b1;
    @(negedge clk);
    psw = ~p; svc = ~s; vexec = ~ex;                               // R9
    guard = 0;
    while (n_done == 0 && guard < 100) begin @(negedge clk); guard++; end
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(n_done == 1, "R8 done count", 64'(n_done), 64'd1);
    check(new_psw == rd, "R8 new psw", new_psw, rd);
    check(n_log == (ec ? 3 : 2), "R6 access count R9", 64'(n_log), 64'(ec ? 3 : 2));
    if (n_log == (ec ? 3 : 2)) begin
      k = 0;
      if (ec) begin
        check(l_we[0] && l_addr[0] == 24'd136 && l_be[0] == 8'hF0, "R2 code req",
              {39'h0, l_we[0], l_addr[0]}, {39'h0, 1'b1, 24'd136});
        check(l_data[0] == exp_code, "R2 R3 code data", l_data[0], exp_code);
        k = 1;
      end
      check(l_we[k] && l_addr[k] == 24'd32 && l_be[k] == 8'hFF, "R4 R6 old req",
            {39'h0, l_we[k], l_addr[k]}, {39'h0, 1'b1, 24'd32});
      check(l_data[k] == exp_old, ec ? "R4 old psw" : "R5 old psw", l_data[k], exp_old);
      check(!l_we[k+1] && l_addr[k+1] == 24'd96 && l_be[k+1] == 8'hFF, "R6 read req",
            {39'h0, l_we[k+1], l_addr[k+1]}, {39'h0, 1'b0, 24'd96});
      check(done_cyc == l_cyc[k+1] + 1, "R8 done timing", 64'(done_cyc),
            64'(l_cyc[k+1] + 1));
    end
  endtask

  initial begin
    #5000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!req && !done && !busy, "R1 reset ctrl", {61'h0, req, done, busy}, 64'h0);
    check(new_psw == 64'h0, "R1 reset psw", new_psw, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req && !busy, "R1 idle after reset", {62'h0, req, busy}, 64'h0);
    for (int s = 0; s < 256; s++)
      for (int m = 0; m < 4; m++)
        run_trial(8'(s), m[0], m[1], (s + m) % 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule